// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block produces the carrier-sense and collision signals that a dual-speed Ethernet PHY presents to its MAC across the MII. It takes the MAC's transmit enable and the line receiver's receive-activity indication, both of which may be asynchronous to the output clock, and resynchronizes them before combining them. Static configuration inputs choose duplex, speed, a serial 10 Mbit/s mode and whether carrier sense covers both directions or the receive side only.

A transmit-duration (jabber) timer counts how long the resynchronized transmit enable has been held. In serial mode at 10 Mbit/s the collision output stops reporting collisions and instead reports that this timer has run out. In full duplex the collision output is always low and carrier sense follows receive activity only. Both outputs are registered, so they are free of glitches in the output clock domain.

Top module: `mii_crs_col`

## Requirements
- R1: While reset is asserted, and after release with both activity inputs low, `crs_o` and `col_o` are 0.
- R2: In half duplex, outside serial 10 Mbit/s mode, `col_o` is the AND of transmit enable and receive activity.
- R3: With `full_dup_i` = 1, `col_o` is 0 in every mode, including serial 10 Mbit/s mode with an expired jabber timer; it follows a change of `full_dup_i` one clock edge later.
- R4: In half duplex with `crs_rx_only_i` = 0, `crs_o` is 1 when either transmit enable or receive activity is 1.
- R5: With `crs_rx_only_i` = 1, `crs_o` follows receive activity only; transmit enable alone leaves it at 0.
- R6: With `full_dup_i` = 1, `crs_o` follows receive activity only, whatever the value of `crs_rx_only_i`.
- R7: While a collision holds (half duplex, both activity inputs 1), `crs_o` stays 1.
- R8: In serial mode (`serial_i` = 1) at 10 Mbit/s (`speed_100_i` = 0), `col_o` reports jabber expiry and not a collision: simultaneous transmit and receive activity with an unexpired timer gives `col_o` = 0.
- R9: The jabber timer expires after `JAB_LIMIT` cycles of synchronized transmit enable; in serial 10 Mbit/s half-duplex mode `col_o` rises exactly `JAB_LIMIT`+3 rising edges after `tx_en_i` rises, and not one edge sooner.
- R10: When transmit enable falls, the timer clears; `col_o` is still 1 three edges later and 0 four edges later.
- R11: A change on `tx_en_i` or `rx_act_i` reaches the outputs exactly three rising edges later (two synchronizer stages and one output register).
- R12: At 100 Mbit/s (`speed_100_i` = 1), `serial_i` has no effect: a long transmit with no receive activity gives `col_o` = 0, and a collision gives `col_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en_i | input | 1 | Transmit enable from the MAC, may be asynchronous |
| rx_act_i | input | 1 | Receive activity from the line receiver, may be asynchronous |
| full_dup_i | input | 1 | 1 selects full duplex |
| speed_100_i | input | 1 | 1 selects 100 Mbit/s, 0 selects 10 Mbit/s |
| serial_i | input | 1 | 1 selects serial mode (effective at 10 Mbit/s only) |
| crs_rx_only_i | input | 1 | 1 makes carrier sense follow receive activity only |
| crs_o | output | 1 | Carrier sense toward the MAC |
| col_o | output | 1 | Collision, or jabber expiry in serial 10 Mbit/s mode |

## Verification
The assertions assume the four configuration inputs are quasi-static: they may change between clock edges but are sampled directly, not through the synchronizer, so a property relating configuration to an output one edge later holds only if the configuration is steady across that edge. They also assume the activity inputs are held for at least one full clock, so every change is seen by the first synchronizer stage. The stimulus changes all inputs at the falling edge, holds each pattern for several cycles, and returns the activity inputs to idle between table entries so the jabber timer never builds up across patterns.

// File: rtl/mii_cs_pkg.sv
package mii_cs_pkg;

  typedef struct packed {
    logic full_dup;
    logic spd100;
    logic serial;
    logic rx_only;
  } cs_cfg_t;

  // Collision output reports the jabber timer instead of a collision
  function automatic logic jab_report(input cs_cfg_t c);
    return c.serial && !c.spd100;
  endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = d_i;
      end else begin : g_rest
        always_comb chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cs_jabber.sv
module cs_jabber #(
  parameter int JAB_LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_s,
  output logic expired_o
);

  localparam int CW = $clog2(JAB_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(JAB_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!tx_s)             cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    else                   cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LIM);

  // R10
  jab_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_s |=> (cnt_q == '0));

  // R9
  jab_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |-> $past(tx_s));

endmodule

// File: rtl/cs_combine.sv
module cs_combine
  import mii_cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cs_cfg_t cfg,
  input  logic    tx_s,
  input  logic    rx_s,
  input  logic    jab_exp,
  output logic    crs_o,
  output logic    col_o
);

  logic crs_d, col_d, crs_q, col_q;
  logic tx_counts;

  always_comb begin
    tx_counts = tx_s && !cfg.rx_only && !cfg.full_dup;
    crs_d     = rx_s || tx_counts;
    if (cfg.full_dup)        col_d = 1'b0;
    else if (jab_report(cfg)) col_d = jab_exp;
    else                      col_d = tx_s && rx_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      crs_q <= crs_d;
      col_q <= col_d;
    end
  end

  assign crs_o = crs_q;
  assign col_o = col_q;

  // R3
  fd_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.full_dup |=> !col_o);

  // R5 R6
  rx_only_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.rx_only || cfg.full_dup) && !rx_s) |=> !crs_o);

  // R7
  collision_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.full_dup && !jab_report(cfg) && tx_s && rx_s) |=> (col_o && crs_o));

  // R8
  serial_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_report(cfg) && !jab_exp) |=> !col_o);

endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col
  import mii_cs_pkg::*;
#(
  parameter int JAB_LIMIT   = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic rx_act_i,
  input  logic full_dup_i,
  input  logic speed_100_i,
  input  logic serial_i,
  input  logic crs_rx_only_i,
  output logic crs_o,
  output logic col_o
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic [1:0] act_s;
  logic       jab_exp;
  cs_cfg_t    cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    cfg.full_dup = full_dup_i;
    cfg.spd100   = speed_100_i;
    cfg.serial   = serial_i;
    cfg.rx_only  = crs_rx_only_i;
  end

  cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({rx_act_i, tx_en_i}),
    .q_o   (act_s)
  );

  cs_jabber #(.JAB_LIMIT(JAB_LIMIT)) u_jab (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tx_s      (act_s[0]),
    .expired_o (jab_exp)
  );

  cs_combine u_comb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cfg     (cfg),
    .tx_s    (act_s[0]),
    .rx_s    (act_s[1]),
    .jab_exp (jab_exp),
    .crs_o   (crs_o),
    .col_o   (col_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!crs_o && !col_o));

endmodule

// File: tb/mii_crs_col_bench.sv
module mii_crs_col_bench;

  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_en, rx_act, fd, spd, ser, rxo;
  logic crs, col;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  mii_crs_col #(.JAB_LIMIT(LIM)) u_mii_crs_col (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en_i       (tx_en),
    .rx_act_i      (rx_act),
    .full_dup_i    (fd),
    .speed_100_i   (spd),
    .serial_i      (ser),
    .crs_rx_only_i (rxo),
    .crs_o         (crs),
    .col_o         (col)
  );

  // [7]tx [6]rx [5]fd [4]spd100 [3]serial [2]rx_only [1]exp crs [0]exp col
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'b1_0_0_1_0_0_1_0,  // R4 tx only
    8'b0_1_0_1_0_0_1_0,  // R4 rx only
    8'b1_1_0_1_0_0_1_1,  // R2 R7 collision
    8'b1_0_0_1_0_1_0_0,  // R5 tx ignored for crs
    8'b1_1_0_1_0_1_1_1,  // R5 R7 rx_only collision
    8'b1_0_1_1_0_0_0_0,  // R6 full duplex tx
    8'b1_1_1_1_0_0_1_0,  // R3 R6 full duplex both
    8'b0_1_1_1_0_0_1_0,  // R6 full duplex rx
    8'b1_1_0_0_0_0_1_1,  // R2 10M nibble collision
    8'b1_1_0_0_1_0_1_0,  // R8 serial, timer not expired
    8'b1_1_0_1_1_0_1_1,  // R12 serial ignored at 100M
    8'b0_0_0_1_0_0_0_0   // R4 idle
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1, 11: return "R4";
      2, 8:     return "R2";
      3, 4:     return "R5";
      5, 7:     return "R6";
      6:        return "R3";
      9:        return "R8";
      default:  return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    tx_en = 0; rx_act = 0; fd = 0; spd = 1; ser = 0; rxo = 0;
    edges(5);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_en = 1; rx_act = 1; fd = 0; spd = 1; ser = 0; rxo = 0;
    edges(4);
    chk("R1", "crs in reset", crs, 1'b0);
    chk("R1", "col in reset", col, 1'b0);
    @(negedge clk);
    tx_en = 0; rx_act = 0;
    rst_n = 1;
    edges(6);
    chk("R1", "crs after reset", crs, 1'b0);
    chk("R1", "col after reset", col, 1'b0);

    for (int i = 0; i < NV; i++) begin
      idle();
      @(negedge clk);
      {tx_en, rx_act, fd, spd, ser, rxo} = VEC[i][7:2];
      edges(4);
      chk(vtag(i), $sformatf("crs vector %0d", i), crs, VEC[i][1]);
      chk(vtag(i), $sformatf("col vector %0d", i), col, VEC[i][0]);
    end

    // R11 latency of three edges
    idle();
    @(negedge clk);
    tx_en = 1; rx_act = 1;
    edges(2);
    chk("R11", "col after 2 edges", col, 1'b0);
    chk("R11", "crs after 2 edges", crs, 1'b0);
    edges(1);
    chk("R11", "col after 3 edges", col, 1'b1);
    chk("R11", "crs after 3 edges", crs, 1'b1);

    // R9 jabber expiry timing in serial 10M
    idle();
    @(negedge clk);
    spd = 0; ser = 1;
    edges(2);
    @(negedge clk);
    tx_en = 1;
    edges(LIM + 2);
    chk("R9", "col one edge before expiry", col, 1'b0);
    edges(1);
    chk("R9", "col at expiry", col, 1'b1);

    // R3 full duplex masks expired jabber
    @(negedge clk);
    fd = 1;
    edges(1);
    chk("R3", "col full duplex with jabber", col, 1'b0);
    @(negedge clk);
    fd = 0;
    edges(1);
    chk("R3", "col back in half duplex", col, 1'b1);

    // R10 clearing when tx drops
    @(negedge clk);
    tx_en = 0;
    edges(3);
    chk("R10", "col three edges after tx drop", col, 1'b1);
    edges(1);
    chk("R10", "col four edges after tx drop", col, 1'b0);

    // R12 long transmit at 100M in serial mode
    idle();
    @(negedge clk);
    ser = 1; tx_en = 1;
    edges(LIM + 10);
    chk("R12", "col long tx at 100M serial", col, 1'b0);
    chk("R4", "crs long tx at 100M", crs, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule